// File: doc/BRIEF.md
# Register Rename Map with Rollback Log

This block renames the architectural registers of one instruction stream onto a larger pool of physical registers. Each request carries two source operands and at most one destination. The sources are looked up in a map table and come back with their physical tags and a ready bit read from a per-tag scoreboard. A destination takes the next tag from a FIFO free list. The map then points at that tag, its scoreboard bit is cleared, and a log entry is appended. The entry holds the request's sequence number, the architectural register, the new tag and the tag that the register had before.

The log is the only recovery structure. A squash to sequence number S walks the log from its young end. Every entry younger than S gives its architectural register back its previous tag, and its new tag returns to the free list. A commit of sequence number C walks the log from its old end. Every entry at or below C releases its previous tag to the free list. Either walk retires one entry per clock cycle. While a walk runs, `busy` is high and rename requests are refused. A writeback port marks a physical tag ready once its value has been produced.

Top module: `rename_hist_unit`

## Requirements
- R1: After reset, architectural register i maps to physical tag i. Every scoreboard bit is ready. The free list holds the remaining tags in ascending order, starting at tag NUM_ARCH, so `free_count` equals NUM_PHYS-NUM_ARCH.
- R2: In the cycle of a request, `src0_tag` and `src1_tag` give the current mapping of `req_src0` and `req_src1`. `src0_ready` and `src1_ready` give the scoreboard bit of those tags as it stood before that clock edge.
- R3: An accepted request with `req_dst_valid` takes the tag at the head of the free list, shown on `dst_tag`, and `dst_prev_tag` shows the destination's old mapping. From the next cycle the destination maps to the new tag and that tag reads not ready. Tags leave the free list in the order they entered it.
- R4: `wb_valid` sets the scoreboard bit of `wb_tag` at the next clock edge.
- R5: A request is refused (`req_accept` low) when `free_count` is less than its number of destinations (`req_dst_valid` is 0 or 1). A refused request changes no state. A request with no destination is accepted even when the free list is empty.
- R6: A squash to S removes log entries whose sequence number is greater than S, youngest first. Each removal restores the map of its architectural register to the previous tag and appends the new tag to the free list.
- R7: A commit of C removes log entries whose sequence number is at most C, oldest first. Each removal appends the previous tag to the free list.
- R8: A commit does nothing when the log is empty or when its oldest entry is younger than C.
- R9: A squash that arrives with an empty log changes no mapping and no free-list state.
- R10: A walk that removes k entries keeps `busy` high for exactly k+1 cycles. `req_accept` stays low while `busy` is high, and also in any cycle where a squash or commit is presented.
- R11: When a squash and a commit arrive in the same idle cycle, the squash is carried out and the commit is dropped.
- R12: The free-list count plus the number of log entries always equals NUM_PHYS-NUM_ARCH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Rename request present |
| req_seq | input | SEQ_W | Sequence number of the request |
| req_src0 | input | AW | First source architectural register |
| req_src1 | input | AW | Second source architectural register |
| req_dst_valid | input | 1 | Request has a destination |
| req_dst | input | AW | Destination architectural register |
| req_accept | output | 1 | Request accepted this cycle |
| src0_tag | output | PW | Physical tag of first source |
| src0_ready | output | 1 | First source operand ready |
| src1_tag | output | PW | Physical tag of second source |
| src1_ready | output | 1 | Second source operand ready |
| dst_tag | output | PW | Newly allocated destination tag |
| dst_prev_tag | output | PW | Tag the destination mapped to before |
| wb_valid | input | 1 | Writeback marks a tag ready |
| wb_tag | input | PW | Tag written back |
| cmt_valid | input | 1 | Commit request |
| cmt_seq | input | SEQ_W | Youngest committed sequence number |
| sq_valid | input | 1 | Squash request |
| sq_seq | input | SEQ_W | Youngest surviving sequence number |
| busy | output | 1 | A squash or commit walk is in progress |
| free_count | output | CW | Number of tags in the free list |

## Verification
Several properties hold on every cycle and are checked that way: tag conservation between the free list and the log, refusal while busy or while the list is empty, single-entry retirement, the effect of a scoreboard clear or set, and the stopping point of each walk. Other behaviour can only be shown by the bench's scenarios against its own model. That covers the exact tag returned for each destination under FIFO reuse, map restoration after squashes of varying depth, and walk length measured in busy cycles. It also covers the dropped commit when both arrive together and the no-effect cases with an empty or too-young log.

// File: rtl/rn_pkg.sv
package rn_pkg;

  typedef enum logic [1:0] {
    WALK_IDLE   = 2'd0,
    WALK_SQUASH = 2'd1,
    WALK_COMMIT = 2'd2
  } walk_mode_e;

  // circular pointer step for a buffer of arbitrary depth
  function automatic int unsigned ring_inc(input int unsigned p, input int unsigned depth);
    return (p + 1 == depth) ? 0 : p + 1;
  endfunction

  function automatic int unsigned ring_dec(input int unsigned p, input int unsigned depth);
    return (p == 0) ? depth - 1 : p - 1;
  endfunction

endpackage

// File: rtl/rn_free_list.sv
module rn_free_list #(
  parameter int DEPTH = 8,
  parameter int TW = 4,
  parameter int BASE = 8,
  localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [TW-1:0] push_tag,
  input  logic          pop,
  output logic [TW-1:0] head_tag,
  output logic [CW-1:0] count
);
  import rn_pkg::*;

  logic [TW-1:0]   mem_q [DEPTH];
  logic [PTRW-1:0] head_q, tail_q;
  logic [CW-1:0]   count_q;

  assign head_tag = mem_q[head_q];
  assign count    = count_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= TW'(BASE + i);
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= CW'(DEPTH);
    end else begin
      if (push) begin
        mem_q[tail_q] <= push_tag;
        tail_q <= PTRW'(ring_inc(32'(tail_q), DEPTH));
      end
      if (pop) head_q <= PTRW'(ring_inc(32'(head_q), DEPTH));
      case ({push, pop})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  p_no_overflow_r12: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> count_q < CW'(DEPTH));
  p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> count_q != '0);

endmodule

// File: rtl/rn_hist_log.sv
module rn_hist_log #(
  parameter int DEPTH = 8,
  parameter int SEQ_W = 16,
  parameter int AW = 3,
  parameter int PW = 4,
  localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [SEQ_W-1:0] push_seq,
  input  logic [AW-1:0]    push_arch,
  input  logic [PW-1:0]    push_new,
  input  logic [PW-1:0]    push_prev,
  input  logic             pop_young,
  input  logic             pop_old,
  output logic [SEQ_W-1:0] young_seq,
  output logic [AW-1:0]    young_arch,
  output logic [PW-1:0]    young_new,
  output logic [PW-1:0]    young_prev,
  output logic [SEQ_W-1:0] old_seq,
  output logic [PW-1:0]    old_prev,
  output logic [CW-1:0]    count
);
  import rn_pkg::*;

  logic [SEQ_W-1:0] seq_q  [DEPTH];
  logic [AW-1:0]    arch_q [DEPTH];
  logic [PW-1:0]    new_q  [DEPTH];
  logic [PW-1:0]    prev_q [DEPTH];
  logic [PTRW-1:0]  head_q, tail_q, young_idx;
  logic [CW-1:0]    count_q;

  assign young_idx  = PTRW'(ring_dec(32'(tail_q), DEPTH));
  assign young_seq  = seq_q[young_idx];
  assign young_arch = arch_q[young_idx];
  assign young_new  = new_q[young_idx];
  assign young_prev = prev_q[young_idx];
  assign old_seq    = seq_q[head_q];
  assign old_prev   = prev_q[head_q];
  assign count      = count_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        seq_q[i]  <= '0;
        arch_q[i] <= '0;
        new_q[i]  <= '0;
        prev_q[i] <= '0;
      end
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else if (push) begin
      seq_q[tail_q]  <= push_seq;
      arch_q[tail_q] <= push_arch;
      new_q[tail_q]  <= push_new;
      prev_q[tail_q] <= push_prev;
      tail_q  <= PTRW'(ring_inc(32'(tail_q), DEPTH));
      count_q <= count_q + 1'b1;
    end else if (pop_young) begin
      tail_q  <= young_idx;
      count_q <= count_q - 1'b1;
    end else if (pop_old) begin
      head_q  <= PTRW'(ring_inc(32'(head_q), DEPTH));
      count_q <= count_q - 1'b1;
    end
  end

  p_log_no_overflow_r12: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> count_q < CW'(DEPTH));
  p_log_no_underflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_young || pop_old) |-> count_q != '0);
  p_one_log_op_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({push, pop_young, pop_old}));

endmodule

// File: rtl/rn_map_table.sv
module rn_map_table #(
  parameter int NUM_ARCH = 8,
  parameter int NUM_PHYS = 16,
  localparam int AW = $clog2(NUM_ARCH),
  localparam int PW = $clog2(NUM_PHYS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_a,
  input  logic [AW-1:0] rd_b,
  input  logic [AW-1:0] rd_c,
  output logic [PW-1:0] tag_a,
  output logic [PW-1:0] tag_b,
  output logic [PW-1:0] tag_c,
  output logic          rdy_a,
  output logic          rdy_b,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_arch,
  input  logic [PW-1:0] wr_tag,
  input  logic          clr_en,
  input  logic [PW-1:0] clr_tag,
  input  logic          set_en,
  input  logic [PW-1:0] set_tag
);
  logic [PW-1:0]       map_q [NUM_ARCH];
  logic [NUM_PHYS-1:0] ready_q;

  assign tag_a = map_q[rd_a];
  assign tag_b = map_q[rd_b];
  assign tag_c = map_q[rd_c];
  assign rdy_a = ready_q[tag_a];
  assign rdy_b = ready_q[tag_b];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_ARCH; i++) map_q[i] <= PW'(i);
    end else if (wr_en) begin
      map_q[wr_arch] <= wr_tag;
    end
  end

  // a clear of a freshly allocated tag takes precedence over a stray set
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready_q <= '1;
    end else begin
      if (set_en) ready_q[set_tag] <= 1'b1;
      if (clr_en) ready_q[clr_tag] <= 1'b0;
    end
  end

  p_clear_takes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> !ready_q[$past(clr_tag)]);
  p_set_takes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && !(clr_en && clr_tag == set_tag)) |=> ready_q[$past(set_tag)]);
  p_map_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> map_q[$past(wr_arch)] == $past(wr_tag));

endmodule

// File: rtl/rename_hist_unit.sv
module rename_hist_unit #(
  parameter int NUM_ARCH = 8,
  parameter int NUM_PHYS = 16,
  parameter int SEQ_W = 16,
  localparam int AW = $clog2(NUM_ARCH),
  localparam int PW = $clog2(NUM_PHYS),
  localparam int FL_DEPTH = NUM_PHYS - NUM_ARCH,
  localparam int CW = $clog2(FL_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [SEQ_W-1:0] req_seq,
  input  logic [AW-1:0]    req_src0,
  input  logic [AW-1:0]    req_src1,
  input  logic             req_dst_valid,
  input  logic [AW-1:0]    req_dst,
  output logic             req_accept,
  output logic [PW-1:0]    src0_tag,
  output logic             src0_ready,
  output logic [PW-1:0]    src1_tag,
  output logic             src1_ready,
  output logic [PW-1:0]    dst_tag,
  output logic [PW-1:0]    dst_prev_tag,
  input  logic             wb_valid,
  input  logic [PW-1:0]    wb_tag,
  input  logic             cmt_valid,
  input  logic [SEQ_W-1:0] cmt_seq,
  input  logic             sq_valid,
  input  logic [SEQ_W-1:0] sq_seq,
  output logic             busy,
  output logic [CW-1:0]    free_count
);
  import rn_pkg::*;

  // arithmetic kept in functions so the bench can restate it independently
  function automatic logic has_room(input logic [CW-1:0] cnt, input logic need);
    return !need || (cnt != '0);
  endfunction

  function automatic logic squash_removes(input logic [SEQ_W-1:0] entry_seq,
                                          input logic [SEQ_W-1:0] target);
    return entry_seq > target;
  endfunction

  function automatic logic commit_removes(input logic [SEQ_W-1:0] entry_seq,
                                          input logic [SEQ_W-1:0] target);
    return entry_seq <= target;
  endfunction

  walk_mode_e       mode_q;
  logic [SEQ_W-1:0] tgt_q;

  logic             idle, take_sq, take_cm, do_alloc;
  logic             sq_step, cm_step, walk_stop;
  logic [PW-1:0]    fl_head;
  logic [CW-1:0]    fl_count, hist_count;
  logic             hist_empty;
  logic [SEQ_W-1:0] y_seq, o_seq;
  logic [AW-1:0]    y_arch;
  logic [PW-1:0]    y_new, y_prev, o_prev;
  logic             fl_push;
  logic [PW-1:0]    fl_push_tag;
  logic             map_wr;
  logic [AW-1:0]    map_wr_arch;
  logic [PW-1:0]    map_wr_tag;

  assign idle       = (mode_q == WALK_IDLE);
  assign hist_empty = (hist_count == '0);
  assign take_sq    = idle && sq_valid;
  assign take_cm    = idle && cmt_valid && !sq_valid;
  assign req_accept = req_valid && idle && !sq_valid && !cmt_valid &&
                      has_room(fl_count, req_dst_valid);
  assign do_alloc   = req_accept && req_dst_valid;

  assign sq_step    = (mode_q == WALK_SQUASH) && !hist_empty && squash_removes(y_seq, tgt_q);
  assign cm_step    = (mode_q == WALK_COMMIT) && !hist_empty && commit_removes(o_seq, tgt_q);
  assign walk_stop  = !idle && !sq_step && !cm_step;

  assign fl_push     = sq_step || cm_step;
  assign fl_push_tag = sq_step ? y_new : o_prev;

  assign map_wr      = do_alloc || sq_step;
  assign map_wr_arch = do_alloc ? req_dst : y_arch;
  assign map_wr_tag  = do_alloc ? fl_head : y_prev;

  assign dst_tag    = fl_head;
  assign busy       = !idle;
  assign free_count = fl_count;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= WALK_IDLE;
      tgt_q  <= '0;
    end else if (take_sq) begin
      mode_q <= WALK_SQUASH;
      tgt_q  <= sq_seq;
    end else if (take_cm) begin
      mode_q <= WALK_COMMIT;
      tgt_q  <= cmt_seq;
    end else if (walk_stop) begin
      mode_q <= WALK_IDLE;
    end
  end

  rn_free_list #(
    .DEPTH (FL_DEPTH),
    .TW    (PW),
    .BASE  (NUM_ARCH)
  ) u_free (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (fl_push),
    .push_tag (fl_push_tag),
    .pop      (do_alloc),
    .head_tag (fl_head),
    .count    (fl_count)
  );

  rn_hist_log #(
    .DEPTH (FL_DEPTH),
    .SEQ_W (SEQ_W),
    .AW    (AW),
    .PW    (PW)
  ) u_log (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (do_alloc),
    .push_seq   (req_seq),
    .push_arch  (req_dst),
    .push_new   (fl_head),
    .push_prev  (dst_prev_tag),
    .pop_young  (sq_step),
    .pop_old    (cm_step),
    .young_seq  (y_seq),
    .young_arch (y_arch),
    .young_new  (y_new),
    .young_prev (y_prev),
    .old_seq    (o_seq),
    .old_prev   (o_prev),
    .count      (hist_count)
  );

  rn_map_table #(
    .NUM_ARCH (NUM_ARCH),
    .NUM_PHYS (NUM_PHYS)
  ) u_map (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_a    (req_src0),
    .rd_b    (req_src1),
    .rd_c    (req_dst),
    .tag_a   (src0_tag),
    .tag_b   (src1_tag),
    .tag_c   (dst_prev_tag),
    .rdy_a   (src0_ready),
    .rdy_b   (src1_ready),
    .wr_en   (map_wr),
    .wr_arch (map_wr_arch),
    .wr_tag  (map_wr_tag),
    .clr_en  (do_alloc),
    .clr_tag (fl_head),
    .set_en  (wb_valid),
    .set_tag (wb_tag)
  );

  p_tag_conserve_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(fl_count) + 32'(hist_count)) == FL_DEPTH);
  p_refuse_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_accept);
  p_refuse_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_dst_valid && fl_count == '0) |-> !req_accept);
  p_squash_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && $past(mode_q) == WALK_SQUASH) |-> (hist_empty || y_seq <= tgt_q));
  p_commit_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && $past(mode_q) == WALK_COMMIT) |-> (hist_empty || o_seq > tgt_q));
  p_squash_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && sq_valid && cmt_valid) |=> mode_q == WALK_SQUASH);

endmodule

// File: tb/rename_hist_unit_tb.sv
module rename_hist_unit_tb;
  localparam int NA = 8;
  localparam int NP = 16;
  localparam int SW = 16;
  localparam int AW = $clog2(NA);
  localparam int PW = $clog2(NP);
  localparam int FD = NP - NA;
  localparam int CW = $clog2(FD + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_dst_valid = 1'b0;
  logic [SW-1:0] req_seq = '0;
  logic [AW-1:0] req_src0 = '0, req_src1 = '0, req_dst = '0;
  logic req_accept, src0_ready, src1_ready, busy;
  logic [PW-1:0] src0_tag, src1_tag, dst_tag, dst_prev_tag;
  logic wb_valid = 1'b0, cmt_valid = 1'b0, sq_valid = 1'b0;
  logic [PW-1:0] wb_tag = '0;
  logic [SW-1:0] cmt_seq = '0, sq_seq = '0;
  logic [CW-1:0] free_count;

  always #2 clk = ~clk;

  rename_hist_unit #(.NUM_ARCH(NA), .NUM_PHYS(NP), .SEQ_W(SW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_seq(req_seq),
    .req_src0(req_src0), .req_src1(req_src1), .req_dst_valid(req_dst_valid),
    .req_dst(req_dst), .req_accept(req_accept), .src0_tag(src0_tag),
    .src0_ready(src0_ready), .src1_tag(src1_tag), .src1_ready(src1_ready),
    .dst_tag(dst_tag), .dst_prev_tag(dst_prev_tag), .wb_valid(wb_valid),
    .wb_tag(wb_tag), .cmt_valid(cmt_valid), .cmt_seq(cmt_seq),
    .sq_valid(sq_valid), .sq_seq(sq_seq), .busy(busy), .free_count(free_count)
  );

  // reference model
  int map_m [NA];
  bit rdy_m [NP];
  int fq [$];
  int h_seq [$], h_arch [$], h_new [$], h_prev [$];
  int seq_ctr = 1;
  int checks = 0, fails = 0;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual 1 expected 0");
    summary();
  end

  task automatic idle_inputs();
    req_valid = 0; req_dst_valid = 0; wb_valid = 0; cmt_valid = 0; sq_valid = 0;
  endtask

  function automatic int model_squash(input int s);
    int k = 0;
    while (h_seq.size() > 0 && h_seq[h_seq.size()-1] > s) begin
      map_m[h_arch[h_arch.size()-1]] = h_prev[h_prev.size()-1];
      fq.push_back(h_new[h_new.size()-1]);
      void'(h_seq.pop_back()); void'(h_arch.pop_back());
      void'(h_new.pop_back()); void'(h_prev.pop_back());
      k++;
    end
    return k;
  endfunction

  function automatic int model_commit(input int c);
    int k = 0;
    while (h_seq.size() > 0 && h_seq[0] <= c) begin
      fq.push_back(h_prev[0]);
      void'(h_seq.pop_front()); void'(h_arch.pop_front());
      void'(h_new.pop_front()); void'(h_prev.pop_front());
      k++;
    end
    return k;
  endfunction

  task automatic do_rename(input string lbl, input int s0, input int s1,
                           input bit dv, input int d);
    bit exp_acc;
    int t;
    @(negedge clk); idle_inputs();
    req_valid = 1; req_seq = SW'(seq_ctr); req_src0 = AW'(s0); req_src1 = AW'(s1);
    req_dst_valid = dv; req_dst = AW'(d);
    #1;
    exp_acc = !(dv && fq.size() == 0);
    check({lbl, " R5 accept"}, int'(req_accept), int'(exp_acc));
    check({lbl, " R2 src0 tag"}, int'(src0_tag), map_m[s0]);
    check({lbl, " R2 src0 ready"}, int'(src0_ready), int'(rdy_m[map_m[s0]]));
    check({lbl, " R2 src1 tag"}, int'(src1_tag), map_m[s1]);
    check({lbl, " R2 src1 ready"}, int'(src1_ready), int'(rdy_m[map_m[s1]]));
    if (dv && exp_acc) begin
      check({lbl, " R3 dst tag"}, int'(dst_tag), fq[0]);
      check({lbl, " R3 prev tag"}, int'(dst_prev_tag), map_m[d]);
    end
    @(posedge clk);
    if (dv && exp_acc) begin
      t = fq.pop_front();
      h_seq.push_back(seq_ctr); h_arch.push_back(d);
      h_new.push_back(t); h_prev.push_back(map_m[d]);
      map_m[d] = t; rdy_m[t] = 0;
    end
    seq_ctr++;
  endtask

  task automatic probe(input string lbl);
    for (int a = 0; a < NA / 2; a++) do_rename(lbl, 2 * a, 2 * a + 1, 0, 0);
  endtask

  task automatic do_wb(input int tag);
    @(negedge clk); idle_inputs();
    wb_valid = 1; wb_tag = PW'(tag);
    @(posedge clk);
    rdy_m[tag] = 1;
  endtask

  // mode 0 squash, 1 commit, 2 squash and commit together
  task automatic do_walk(input string lbl, input int mode, input int tgt,
                         input int ctgt, input bit try_req);
    int k, n;
    @(negedge clk); idle_inputs();
    if (mode != 1) begin sq_valid = 1; sq_seq = SW'(tgt); end
    if (mode == 1) begin cmt_valid = 1; cmt_seq = SW'(tgt); end
    if (mode == 2) begin cmt_valid = 1; cmt_seq = SW'(ctgt); end
    #1;
    check({lbl, " R10 accept while walk presented"}, int'(req_accept), 0);
    @(posedge clk);
    k = (mode == 1) ? model_commit(tgt) : model_squash(tgt);
    n = 0;
    forever begin
      @(negedge clk); idle_inputs();
      if (!busy) break;
      n++;
      if (try_req && n == 1) begin
        req_valid = 1; req_dst_valid = 1; req_dst = '0;
        #1;
        check({lbl, " R10 refused while busy"}, int'(req_accept), 0);
        req_valid = 0; req_dst_valid = 0;
      end
    end
    check({lbl, " R10 busy cycles"}, n, k + 1);
    check({lbl, " R12 free count"}, int'(free_count), fq.size());
  endtask

  initial begin
    int op, a, b, d, r;
    for (int i = 0; i < NA; i++) map_m[i] = i;
    for (int i = 0; i < NP; i++) rdy_m[i] = 1;
    for (int i = NA; i < NP; i++) fq.push_back(i);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    // R1 reset state
    check("R1 free count", int'(free_count), FD);
    check("R1 busy", int'(busy), 0);
    probe("R1 identity");

    // R8 commit and R9 squash on empty log
    do_walk("R8 empty commit", 1, 100, 0, 0);
    do_walk("R9 empty squash", 0, 0, 0, 0);
    probe("R9 map kept");

    // R3 / R4 readiness
    do_rename("R3 alloc", 3, 3, 1, 3);
    probe("R3 after alloc");
    do_wb(map_m[3]);
    probe("R4 after wb");

    // R5 exhaust the free list
    for (int i = 0; i < FD; i++) do_rename("R5 fill", i % NA, 0, 1, i % NA);
    check("R5 empty list", int'(free_count), 0);
    do_rename("R5 refused", 1, 2, 1, 5);
    do_rename("R5 no-dst accepted", 1, 2, 0, 5);
    probe("R5 map unchanged");

    // R8 commit below the oldest entry
    do_walk("R8 too young", 1, h_seq[0] - 1, 0, 0);
    // R7 partial commit, R6 partial squash with busy refusal
    do_walk("R7 commit", 1, h_seq[2], 0, 1);
    probe("R7 map");
    do_walk("R6 squash", 0, h_seq[2], 0, 1);
    probe("R6 restore");
    // R11 squash wins over commit
    do_rename("R11 fill", 4, 5, 1, 6);
    do_rename("R11 fill", 6, 7, 1, 6);
    do_walk("R11 both", 2, h_seq[0], seq_ctr, 0);
    probe("R11 map");
    do_walk("R7 drain", 1, seq_ctr, 0, 0);

    // constrained random mix
    void'($urandom(32'd2024));
    for (int it = 0; it < 400; it++) begin
      op = $urandom_range(9, 0);
      a = $urandom_range(NA - 1, 0);
      b = $urandom_range(NA - 1, 0);
      d = $urandom_range(NA - 1, 0);
      if (op <= 4) do_rename("R3 rand", a, b, $urandom_range(3, 0) != 0, d);
      else if (op <= 5) do_wb($urandom_range(NP - 1, 0));
      else if (op <= 7) begin
        r = $urandom_range(seq_ctr, 0);
        do_walk("R7 rand", 1, r, 0, 0);
      end else if (op == 8) begin
        r = $urandom_range(seq_ctr, 0);
        do_walk("R6 rand", 0, r, 0, 0);
      end else probe("R2 rand");
    end
    do_walk("R7 final", 1, seq_ctr, 0, 0);
    check("R12 all free", int'(free_count), FD);
    summary();
  end
endmodule